// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM into a usable state before any normal traffic reaches it. From the moment reset is released it keeps the clock-enable and data-mask pins high and drives only no-operation commands. It does this until a programmable stabilization interval has passed. It then runs a fixed series of commands:

1. One precharge of every bank.
2. A programmable number of auto-refresh commands, eight or more.
3. One mode register set, which loads the value presented on `mode_val`.

Between commands it inserts the row-precharge, refresh-cycle and mode-register delays, each given in clock cycles.

When the last delay has run out, `init_done` goes high and stays high until the next reset. A controller that shares the SDRAM pins with this block uses `init_done` to take over the command bus. This block never accepts a command from outside. After it finishes, it keeps driving no-operation commands.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and for the first T_SETTLE cycles after reset is released (the release cycle counted as cycle 0), the command pins carry only NOP and `init_done` is low. The command encoding on {cs_n, ras_n, cas_n, we_n} is NOP = 0111.
- R2: The first command other than NOP is a precharge-all (0010) in cycle T_SETTLE. It drives address bit AP_BIT high and the bank pins to zero.
- R3: The first auto-refresh (0001) comes exactly T_RP cycles after the precharge-all, and only NOPs lie in between.
- R4: Exactly N_REF auto-refresh commands are issued, each one T_RC cycles after the one before, with only NOPs between them.
- R5: The mode register set (0000) comes T_RC cycles after the last auto-refresh. It carries the `mode_val` present in that same cycle on the address pins, with the bank pins at zero.
- R6: `init_done` rises exactly T_MRD cycles after the mode register set. It then stays high, and only NOP is driven, until reset.
- R7: `cke` and `dqm` are high in every cycle, both during reset and after it.
- R8: No command code other than NOP, precharge, auto-refresh and mode register set ever appears, and every cycle that is not a scheduled command is NOP.
- R9: Asserting reset part-way through the sequence returns the pins to NOP with `init_done` low. The whole sequence then restarts from the stabilization wait.
- R10: T_RP, T_RC and T_MRD must be at least 2, T_SETTLE at least 1, and N_REF at least 8. The timing above holds for any such values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_val | input | ADDR_W | Value written to the mode register (burst length, CAS latency) |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | BA_W | Bank select pins |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
Two events collide in one cycle: the refresh-cycle wait for the final auto-refresh runs out, and the refresh counter reaches N_REF. In that cycle the sequencer must choose the mode register set rather than one more refresh. The bench runs full sequences and records the cycle of every command. It then judges the result by the exact refresh count and by the mode register set appearing T_RC after the last refresh. A second collision is a change of `mode_val` in the cycle just before, or just after, the mode register set. The bench checks that the address pins carry the value present in the issuing cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRC,
    ST_MRS,
    ST_TMRD,
    ST_DONE
  } state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int bits_for(input int v);
    int w;
    w = $clog2(v + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // last cycle of a wait
  assign expire = run && (cnt == CNT_W'(1));
endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
  parameter int N_REF = 8,
  parameter int REF_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  output logic last
);
  logic [REF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (bump && cnt != REF_W'(N_REF)) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == REF_W'(N_REF));
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int T_RP  = 3,
  parameter int T_RC  = 7,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             last_ref,
  output state_e           state,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             run,
  output logic             bump
);
  state_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SETTLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    run      = 1'b0;
    bump     = 1'b0;
    case (state)
      ST_SETTLE: begin
        run = 1'b1;
        if (expire) nxt = ST_PRE;
      end
      ST_PRE: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RP - 1);
        nxt      = ST_TRP;
      end
      ST_TRP: begin
        run = 1'b1;
        if (expire) nxt = ST_REF;
      end
      ST_REF: begin
        bump     = 1'b1;
        load     = 1'b1;
        load_val = CNT_W'(T_RC - 1);
        nxt      = ST_TRC;
      end
      ST_TRC: begin
        run = 1'b1;
        if (expire) nxt = last_ref ? ST_MRS : ST_REF;
      end
      ST_MRS: begin
        load     = 1'b1;
        load_val = CNT_W'(T_MRD - 1);
        nxt      = ST_TMRD;
      end
      ST_TMRD: begin
        run = 1'b1;
        if (expire) nxt = ST_DONE;
      end
      default: nxt = ST_DONE;
    endcase
  end
endmodule

// File: rtl/sdram_init_drive.sv
module sdram_init_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  state_e            state,
  input  logic [ADDR_W-1:0] mode_val,
  output logic [3:0]        pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  always_comb begin
    pins = CMD_NOP;
    addr = '0;
    ba   = '0;
    case (state)
      ST_PRE: begin pins = CMD_PRE; addr = ALL_BANKS; end
      ST_REF: pins = CMD_REF;
      ST_MRS: begin pins = CMD_MRS; addr = mode_val; end
      default: pins = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int AP_BIT   = 10,
  parameter int T_SETTLE = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 7,
  parameter int T_MRD    = 2,
  parameter int N_REF    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic              dqm,
  output logic              init_done
);
  localparam int CNT_W = bits_for(max_of4(T_SETTLE, T_RP, T_RC, T_MRD));
  localparam int REF_W = bits_for(N_REF);

  state_e           state;
  logic             load, run, bump;
  logic [CNT_W-1:0] load_val;
  logic [3:0]       pins;

  // named events for the checker
  logic ev_expire;
  logic ev_last_ref;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(T_SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .run(run), .expire(ev_expire)
  );

  sdram_init_refcnt #(.N_REF(N_REF), .REF_W(REF_W)) u_refcnt (
    .clk(clk), .rst_n(rst_n), .bump(bump), .last(ev_last_ref)
  );

  sdram_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .expire(ev_expire), .last_ref(ev_last_ref),
    .state(state), .load(load), .load_val(load_val), .run(run), .bump(bump)
  );

  sdram_init_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_drive (
    .state(state), .mode_val(mode_val), .pins(pins), .addr(addr), .ba(ba)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = pins;
  assign cke       = 1'b1;
  assign dqm       = 1'b1;
  assign init_done = (state == ST_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_cs_n,
  input logic              cmd_ras_n,
  input logic              cmd_cas_n,
  input logic              cmd_we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] mode_val,
  input logic              init_done,
  input logic              ev_expire,
  input logic              ev_last_ref
);
  logic [3:0] c;
  assign c = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0111 || c == 4'b0010 || c == 4'b0001 || c == 4'b0000);

  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0010 |-> addr[AP_BIT] && ba == '0);

  a_r3_nop_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0010 |=> c == 4'b0111);

  a_r4_ref_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0001 |-> !init_done);

  a_r5_mrs_operand: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0000 |-> addr == mode_val && ba == '0);

  a_r5_mrs_after_last_ref: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0000 |-> $past(ev_last_ref) && $past(ev_expire));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> c == 4'b0111);
endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
  .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .addr(addr), .ba(ba),
  .mode_val(mode_val), .init_done(init_done), .ev_expire(ev_expire),
  .ev_last_ref(ev_last_ref)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int AP_BIT = 10;
  localparam int T_S    = 50;
  localparam int T_RP   = 3;
  localparam int T_RC   = 5;
  localparam int T_MRD  = 2;
  localparam int N_REF  = 8;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  // expected schedule, counted from the reset-release cycle (index 0)
  localparam int E_PRE  = T_S;
  localparam int E_MRS  = T_S + T_RP + N_REF * T_RC;
  localparam int E_DONE = E_MRS + T_MRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] mode_val = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, init_done;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .T_SETTLE(T_S),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .N_REF(N_REF)
  ) i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .mode_val(mode_val),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .addr(addr), .ba(ba), .cke(cke), .dqm(dqm), .init_done(init_done)
  );

  function automatic logic [3:0] pins_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reset held: R1, R7
  task automatic check_in_reset(input string tag);
    #1;
    check(pins_now() == NOP, "R1", {tag, " cmd in reset"}, pins_now(), NOP);
    check(init_done == 1'b0, "R1", {tag, " done in reset"}, init_done, 0);
    check(cke && dqm, "R7", {tag, " cke/dqm in reset"}, {cke, dqm}, 3);
  endtask

  // full sequence; mode_val switches to mode_b at index switch_at
  task automatic run_seq(input logic [ADDR_W-1:0] mode_a, input logic [ADDR_W-1:0] mode_b,
                         input int switch_at, input logic [ADDR_W-1:0] exp_mrs, input string tag);
    int pre_at = -1, mrs_at = -1, done_at = -1, n_ref = 0;
    int ref_bad = 0, stray = 0, low_pins = 0, drop = 0, early = 0;
    logic [ADDR_W-1:0] pre_addr = '0, mrs_addr = '0;
    logic [BA_W-1:0] pre_ba = '0, mrs_ba = '0;
    rst_n = 1'b0;
    mode_val = mode_a;
    repeat (3) @(negedge clk);
    check_in_reset(tag);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      if (i == switch_at) mode_val = mode_b;
      #1;
      if (!(cke && dqm)) low_pins++;
      if (done_at >= 0 && !init_done) drop++;
      if (init_done && done_at < 0) done_at = i;
      case (pins_now())
        NOP: ;
        PRE: begin
          if (pre_at < 0) begin pre_at = i; pre_addr = addr; pre_ba = ba; end
          else stray++;
        end
        REF: begin
          if (i != E_PRE + T_RP + n_ref * T_RC) ref_bad++;
          n_ref++;
        end
        MRS: begin
          if (mrs_at < 0) begin mrs_at = i; mrs_addr = addr; mrs_ba = ba; end
          else stray++;
        end
        default: stray++;
      endcase
      if (pins_now() != NOP && (i < T_S || init_done)) early++;
      if (done_at >= 0 && i >= done_at + 20) break;
      @(negedge clk);
    end
    check(pre_at == E_PRE, "R2", {tag, " precharge cycle"}, pre_at, E_PRE);
    check(pre_addr[AP_BIT] == 1'b1 && pre_ba == '0, "R2", {tag, " precharge all-bank operand"},
          {pre_addr, pre_ba}, (1 << (AP_BIT + BA_W)));
    check(early == 0, "R1", {tag, " command during settle or after done"}, early, 0);
    check(n_ref == N_REF, "R4", {tag, " refresh count"}, n_ref, N_REF);
    check(ref_bad == 0, "R3", {tag, " refresh spacing (tRP then tRC)"}, ref_bad, 0);
    check(mrs_at == E_MRS, "R5", {tag, " mode set cycle"}, mrs_at, E_MRS);
    check(mrs_addr == exp_mrs, "R5", {tag, " mode set address"}, mrs_addr, exp_mrs);
    check(mrs_ba == '0, "R5", {tag, " mode set bank pins"}, mrs_ba, 0);
    check(done_at == E_DONE, "R6", {tag, " done rise cycle"}, done_at, E_DONE);
    check(drop == 0, "R6", {tag, " done stays high"}, drop, 0);
    check(low_pins == 0, "R7", {tag, " cke/dqm held"}, low_pins, 0);
    check(stray == 0, "R8", {tag, " unexpected command codes"}, stray, 0);
  endtask

  task automatic t_basic();
    run_seq(13'h0032, 13'h0032, -1, 13'h0032, "basic");
  endtask

  // mode_val changes the cycle before the mode set: new value expected (R5)
  task automatic t_mode_change_before();
    run_seq(13'h0021, 13'h0033, E_MRS - 1, 13'h0033, "mode_late");
  endtask

  // mode_val changes the cycle after the mode set: old value expected (R5)
  task automatic t_mode_change_after();
    run_seq(13'h0022, 13'h1FFF, E_MRS + 1, 13'h0022, "mode_after");
  endtask

  // reset part way through the refresh phase, then a clean restart (R9, R10)
  task automatic t_reset_midway();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (T_S + T_RP + 2 * T_RC) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pins_now() == NOP, "R9", "cmd right after mid reset", pins_now(), NOP);
    check(init_done == 1'b0, "R9", "done right after mid reset", init_done, 0);
    run_seq(13'h0030, 13'h0030, -1, 13'h0030, "R9_restart");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_basic();
    t_mode_change_before();
    t_mode_change_after();
    t_reset_midway();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule